// File: doc/BRIEF.md
# Packet FIFO Adapter with CRC-32 Append and Check

This block connects a byte-wide host packet interface to a MAC-side frame stream. On the transmit side it forwards host bytes one cycle late. It can add the IEEE 802.3 CRC-32 as four extra bytes after the final data byte. That is done either for every frame or, when the global setting is off, only for frames that request it with a per-frame flag. The MAC side takes one byte per cycle and cannot wait. If the host leaves a hole in the middle of a frame, one of two things happens. In encoded-packet signalling, with transmit flow control enabled, the block pauses the link with a flow-control output. Otherwise it aborts the frame, latches a sticky underrun flag and discards the rest of that frame.

On the receive side the MAC byte stream passes to the host one cycle late. The block runs a CRC-32 over every byte, so the final four bytes, being the CRC, drive the register to the fixed 802.3 residue when the frame is intact. It reports a two-bit status alongside the final byte of each frame. A loopback setting feeds the transmit stream, including any appended CRC, into the receiver and silences the MAC transmit outputs. The receive flow-control output follows a pause request when that is enabled, and a force setting holds it high in encoded-packet signalling.

Top module: `pfi_crc_adapter`

## Requirements
- R1: The appended CRC is four bytes holding the bitwise complement of the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones) over the frame data, least-significant byte first. `mac_tx_last` is set on the fourth CRC byte only.
- R2: With `cfg_crc_append`=1 a CRC is appended whatever `tx_crc_req` says. With `cfg_crc_append`=0 a CRC is appended only when `tx_crc_req` is 1 on the final byte; otherwise `mac_tx_last` is set on the final data byte.
- R3: A host byte accepted at a clock edge (`tx_valid` and `tx_ready` both 1) appears unchanged on `mac_tx_data`, with `mac_tx_valid`=1, in the cycle after that edge. `tx_ready` is 0 while CRC bytes are being sent.
- R4: With `cfg_crc_check`=1, `rx_status` bit 0 (CRC error) is 0 for a frame whose last four bytes are its correct CRC and 1 if any byte is corrupted. `rx_status` is presented with `rx_last` and is 0 on every other byte.
- R5: With `cfg_crc_check`=1, a frame of fewer than four bytes returns `rx_status`=2'b11: bit 1 means too short and bit 0 means CRC error.
- R6: With `cfg_crc_check`=0, `rx_status` is 2'b00 even for a corrupted frame.
- R7: With `cfg_loopback`=1, `mac_tx_valid` stays 0 and the transmitted bytes, including the CRC, come out on the receive host outputs two cycles after acceptance. The `mac_rx_*` inputs are ignored.
- R8: `cfg_sig_mode` encodes 00 as GMII style and 01 as encoded packet, with 10 and 11 reserved. `cfg_force_fc`=1 drives `link_rx_fc` to 1 in mode 01, whatever `cfg_rx_fc_en` and `rx_pause_req` are, and has no effect in any other mode.
- R9: Without a force, `link_rx_fc` equals `cfg_rx_fc_en` AND `rx_pause_req`, in every mode.
- R10: Suppose a frame has started and the host holds `tx_valid` at 0, with `cfg_tx_fc_en`=1 and mode 01. Then `link_tx_fc` is 1 for each such cycle, no MAC byte is sent, and the frame resumes intact with no underrun.
- R11: The same hole in any other configuration is an underrun. `mac_tx_abort` pulses for one cycle and `tx_underrun` sets and stays set until reset. The remaining host bytes of that frame are accepted and dropped, so no `mac_tx_last` or CRC follows.
- R12: While reset is held and just after it, `tx_ready`=1 and `mac_tx_valid`, `rx_valid` and `tx_underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_crc_append | input | 1 | Append a CRC to every transmitted frame |
| cfg_crc_check | input | 1 | Check the CRC of received frames |
| cfg_loopback | input | 1 | Route the transmit stream into the receiver |
| cfg_rx_fc_en | input | 1 | Let a pause request raise receive flow control |
| cfg_tx_fc_en | input | 1 | Allow transmit flow control on a data hole |
| cfg_force_fc | input | 1 | Force receive flow control (mode 01 only) |
| cfg_sig_mode | input | 2 | Signalling mode: 00 GMII style, 01 encoded packet |
| rx_pause_req | input | 1 | Internal request for receive flow control |
| tx_valid | input | 1 | Host transmit byte valid |
| tx_data | input | 8 | Host transmit byte |
| tx_last | input | 1 | Final data byte of the frame |
| tx_crc_req | input | 1 | Per-frame CRC request, sampled with tx_last |
| tx_ready | output | 1 | Block accepts a host byte |
| mac_tx_valid | output | 1 | MAC transmit byte valid |
| mac_tx_data | output | 8 | MAC transmit byte |
| mac_tx_last | output | 1 | Final byte of the MAC frame |
| mac_tx_abort | output | 1 | One-cycle abort of the current frame |
| mac_rx_valid | input | 1 | MAC receive byte valid |
| mac_rx_data | input | 8 | MAC receive byte |
| mac_rx_last | input | 1 | Final received byte |
| rx_valid | output | 1 | Host receive byte valid |
| rx_data | output | 8 | Host receive byte |
| rx_last | output | 1 | Final byte of a received frame |
| rx_status | output | 2 | Bit 0 CRC error, bit 1 too short; valid with rx_last |
| link_tx_fc | output | 1 | Transmit flow control toward the link |
| link_rx_fc | output | 1 | Receive flow control toward the link |
| tx_underrun | output | 1 | Sticky transmit underrun flag |

## Verification
The hardest situation to reach is a hole inside a frame. The bench must be sure that the gap cycle falls after at least one byte has been accepted and before the final byte. The send task therefore lowers `tx_valid` for a chosen number of cycles just before a chosen byte index. It is run once with encoded-packet mode and transmit flow control enabled, where the frame must resume with a correct CRC. It is run again in GMII mode, where the same gap must abort the frame and drop the tail. A second hard case is loopback while the MAC receive inputs carry traffic. The bench holds `mac_rx_valid` high with a fixed pattern during the loopback frame and requires that only the transmitted bytes reach the host.

// File: rtl/pfi_pkg.sv
// Shared constants, types and the CRC-32 byte step for the packet FIFO adapter.
// Assumes bytes enter the CRC least-significant bit first (reflected CRC-32).
package pfi_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CRC_W     = 32;
    localparam int unsigned CRC_BYTES = CRC_W / BYTE_W;
    localparam int unsigned STAT_W    = 2;

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFF_FFFF;
    // Residue 0xC704DD7B in normal bit order, held bit-reversed in this register
    localparam logic [CRC_W-1:0] CRC_RESIDUE   = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        SIG_GMII  = 2'b00,
        SIG_ENC   = 2'b01,
        SIG_RSV_A = 2'b10,
        SIG_RSV_B = 2'b11
    } sig_mode_e;

    // Advance the reflected CRC register by one byte
    function automatic logic [CRC_W-1:0] crc32_step(input logic [CRC_W-1:0] c,
                                                    input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < BYTE_W; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pfi_flow_ctl.sv
// Flow-control decode for the packet FIFO adapter.
// Assumes the configuration inputs are static while frames are in flight.
module pfi_flow_ctl
    import pfi_pkg::*;
(
    input  sig_mode_e mode,
    input  logic      force_fc,
    input  logic      rx_fc_en,
    input  logic      rx_pause_req,
    input  logic      tx_fc_en,
    output logic      link_rx_fc,
    output logic      tx_fc_allowed
);

    logic enc_mode;

    // Decode the signalling mode and combine the flow-control sources
    always_comb begin
        enc_mode      = (mode == SIG_ENC);
        link_rx_fc    = (enc_mode && force_fc) || (rx_fc_en && rx_pause_req);
        tx_fc_allowed = enc_mode && tx_fc_en;
    end

endmodule

// File: rtl/pfi_tx_path.sv
// Transmit path: forwards host bytes to the MAC stream one cycle later, appends
// the CRC-32 after the final byte when asked, and handles mid-frame data holes
// by pausing (flow control) or aborting with a sticky underrun flag.
// Assumes the MAC side accepts one byte every cycle without backpressure.
module pfi_tx_path
    import pfi_pkg::*;
#(
    parameter int unsigned NUM_CRC_BYTES = CRC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_append,
    input  logic              tx_fc_allowed,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_crc_req,
    output logic              s_ready,
    output logic              q_valid,
    output logic [BYTE_W-1:0] q_data,
    output logic              q_last,
    output logic              q_abort,
    output logic              tx_fc,
    output logic              underrun
);

    localparam int unsigned IDX_W = (NUM_CRC_BYTES > 1) ? $clog2(NUM_CRC_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_CRC_BYTES - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_CRC, ST_DROP} tx_state_e;

    tx_state_e        state;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] fcs;
    logic [IDX_W-1:0] crc_idx;
    logic             accept;

    // Handshake, CRC update and flow-control decode
    always_comb begin
        s_ready  = (state != ST_CRC);
        accept   = s_valid && s_ready;
        crc_base = (state == ST_IDLE) ? CRC_PRESET : crc_q;
        crc_next = crc32_step(crc_base, s_data);
        fcs      = ~crc_q;
        tx_fc    = (state == ST_DATA) && !s_valid && tx_fc_allowed;
    end

    // Frame sequencing and registered MAC-side outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            crc_q    <= CRC_PRESET;
            crc_idx  <= '0;
            q_valid  <= 1'b0;
            q_data   <= '0;
            q_last   <= 1'b0;
            q_abort  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            q_valid <= 1'b0;
            q_last  <= 1'b0;
            q_abort <= 1'b0;
            case (state)
                ST_IDLE, ST_DATA: begin
                    if (accept) begin
                        q_valid <= 1'b1;
                        q_data  <= s_data;
                        crc_q   <= crc_next;
                        if (s_last) begin
                            if (cfg_append || s_crc_req) begin
                                state   <= ST_CRC;
                                crc_idx <= '0;
                            end else begin
                                q_last <= 1'b1;
                                state  <= ST_IDLE;
                            end
                        end else begin
                            state <= ST_DATA;
                        end
                    end else if (state == ST_DATA && !tx_fc_allowed) begin
                        underrun <= 1'b1;
                        q_abort  <= 1'b1;
                        state    <= ST_DROP;
                    end
                end
                ST_CRC: begin
                    q_valid <= 1'b1;
                    q_data  <= fcs[{crc_idx, 3'b000} +: BYTE_W];
                    if (crc_idx == IDX_LAST) begin
                        q_last <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        crc_idx <= crc_idx + 1'b1;
                    end
                end
                default: begin
                    if (accept && s_last) state <= ST_IDLE;
                end
            endcase
        end
    end

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);                                          // R11
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q_abort |=> !q_abort);                                           // R11
    AST_CRC_TAIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CRC && crc_idx == IDX_LAST) |=> (q_valid && q_last)); // R1
    AST_PAUSE_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fc |=> (!q_valid && !q_abort));                               // R10

endmodule

// File: rtl/pfi_rx_path.sv
// Receive path: forwards MAC bytes to the host one cycle later, runs a CRC-32
// over every byte and reports error and too-short status with the final byte.
// Assumes the trailing four bytes of each frame are its CRC.
module pfi_rx_path
    import pfi_pkg::*;
#(
    parameter int unsigned NUM_CRC_BYTES = CRC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    output logic [STAT_W-1:0] out_status
);

    localparam int unsigned CNT_W = $clog2(NUM_CRC_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_CRC_BYTES);

    logic             mid_q;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_base;
    logic [CNT_W-1:0] cnt_next;
    logic             too_short;
    logic             bad_crc;

    // Running CRC, saturating byte count and end-of-frame verdict
    always_comb begin
        crc_next  = crc32_step(mid_q ? crc_q : CRC_PRESET, in_data);
        cnt_base  = mid_q ? cnt_q : '0;
        cnt_next  = (cnt_base == CNT_FULL) ? cnt_base : cnt_base + 1'b1;
        too_short = (cnt_next < CNT_FULL);
        bad_crc   = too_short || (crc_next != CRC_RESIDUE);
    end

    // Registered host-side outputs and per-frame state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q      <= 1'b0;
            crc_q      <= CRC_PRESET;
            cnt_q      <= '0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_last   <= 1'b0;
            out_status <= '0;
        end else begin
            out_valid  <= in_valid;
            out_last   <= in_valid && in_last;
            out_status <= '0;
            if (in_valid) begin
                out_data <= in_data;
                if (in_last) begin
                    mid_q      <= 1'b0;
                    out_status <= chk_en ? {too_short, bad_crc} : '0;
                end else begin
                    mid_q <= 1'b1;
                    crc_q <= crc_next;
                    cnt_q <= cnt_next;
                end
            end
        end
    end

    AST_STATUS_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_status != '0) |-> (out_valid && out_last));                 // R4
    AST_SHORT_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        out_status[1] |-> out_status[0]);                                // R5

endmodule

// File: rtl/pfi_crc_adapter.sv
// Top of the packet FIFO adapter: transmit path, receive path, flow-control
// decode and the loopback routing between them.
// Assumes configuration changes only between frames.
module pfi_crc_adapter
    import pfi_pkg::*;
#(
    parameter int unsigned NUM_CRC_BYTES = CRC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_crc_append,
    input  logic              cfg_crc_check,
    input  logic              cfg_loopback,
    input  logic              cfg_rx_fc_en,
    input  logic              cfg_tx_fc_en,
    input  logic              cfg_force_fc,
    input  logic [1:0]        cfg_sig_mode,
    input  logic              rx_pause_req,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic              tx_crc_req,
    output logic              tx_ready,
    output logic              mac_tx_valid,
    output logic [BYTE_W-1:0] mac_tx_data,
    output logic              mac_tx_last,
    output logic              mac_tx_abort,
    input  logic              mac_rx_valid,
    input  logic [BYTE_W-1:0] mac_rx_data,
    input  logic              mac_rx_last,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_last,
    output logic [STAT_W-1:0] rx_status,
    output logic              link_tx_fc,
    output logic              link_rx_fc,
    output logic              tx_underrun
);

    logic              fc_allowed;
    logic              q_valid;
    logic [BYTE_W-1:0] q_data;
    logic              q_last;
    logic              q_abort;
    logic              rin_valid;
    logic [BYTE_W-1:0] rin_data;
    logic              rin_last;

    pfi_flow_ctl u_flow (
        .mode          (sig_mode_e'(cfg_sig_mode)),
        .force_fc      (cfg_force_fc),
        .rx_fc_en      (cfg_rx_fc_en),
        .rx_pause_req  (rx_pause_req),
        .tx_fc_en      (cfg_tx_fc_en),
        .link_rx_fc    (link_rx_fc),
        .tx_fc_allowed (fc_allowed)
    );

    pfi_tx_path #(.NUM_CRC_BYTES(NUM_CRC_BYTES)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_append    (cfg_crc_append),
        .tx_fc_allowed (fc_allowed),
        .s_valid       (tx_valid),
        .s_data        (tx_data),
        .s_last        (tx_last),
        .s_crc_req     (tx_crc_req),
        .s_ready       (tx_ready),
        .q_valid       (q_valid),
        .q_data        (q_data),
        .q_last        (q_last),
        .q_abort       (q_abort),
        .tx_fc         (link_tx_fc),
        .underrun      (tx_underrun)
    );

    // Loopback routing: silence the MAC side and feed the receiver from transmit
    always_comb begin
        mac_tx_valid = q_valid && !cfg_loopback;
        mac_tx_data  = q_data;
        mac_tx_last  = q_last && !cfg_loopback;
        mac_tx_abort = q_abort && !cfg_loopback;
        rin_valid    = cfg_loopback ? q_valid : mac_rx_valid;
        rin_data     = cfg_loopback ? q_data  : mac_rx_data;
        rin_last     = cfg_loopback ? q_last  : mac_rx_last;
    end

    pfi_rx_path #(.NUM_CRC_BYTES(NUM_CRC_BYTES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_en     (cfg_crc_check),
        .in_valid   (rin_valid),
        .in_data    (rin_data),
        .in_last    (rin_last),
        .out_valid  (rx_valid),
        .out_data   (rx_data),
        .out_last   (rx_last),
        .out_status (rx_status)
    );

    AST_LOOP_MAC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_loopback && $stable(cfg_loopback)) |-> (!mac_tx_valid && !mac_tx_abort)); // R7

endmodule

// File: tb/pfi_crc_adapter_tb.sv
`timescale 1ns/1ps
module pfi_crc_adapter_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_crc_append, cfg_crc_check, cfg_loopback;
    logic       cfg_rx_fc_en, cfg_tx_fc_en, cfg_force_fc;
    logic [1:0] cfg_sig_mode;
    logic       rx_pause_req;
    logic       tx_valid, tx_last, tx_crc_req, tx_ready;
    logic [7:0] tx_data;
    logic       mac_tx_valid, mac_tx_last, mac_tx_abort;
    logic [7:0] mac_tx_data;
    logic       mac_rx_valid, mac_rx_last;
    logic [7:0] mac_rx_data;
    logic       rx_valid, rx_last;
    logic [7:0] rx_data;
    logic [1:0] rx_status;
    logic       link_tx_fc, link_rx_fc, tx_underrun;

    always #2 clk = ~clk;

    pfi_crc_adapter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_crc_append(cfg_crc_append), .cfg_crc_check(cfg_crc_check),
        .cfg_loopback(cfg_loopback), .cfg_rx_fc_en(cfg_rx_fc_en),
        .cfg_tx_fc_en(cfg_tx_fc_en), .cfg_force_fc(cfg_force_fc),
        .cfg_sig_mode(cfg_sig_mode), .rx_pause_req(rx_pause_req),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_crc_req(tx_crc_req), .tx_ready(tx_ready),
        .mac_tx_valid(mac_tx_valid), .mac_tx_data(mac_tx_data),
        .mac_tx_last(mac_tx_last), .mac_tx_abort(mac_tx_abort),
        .mac_rx_valid(mac_rx_valid), .mac_rx_data(mac_rx_data),
        .mac_rx_last(mac_rx_last),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_status(rx_status), .link_tx_fc(link_tx_fc),
        .link_rx_fc(link_rx_fc), .tx_underrun(tx_underrun)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: sample 1 ns after the falling edge
    logic [7:0] tx_cap [0:255];
    logic       tx_lcap [0:255];
    logic [7:0] rx_cap [0:255];
    int  tx_n = 0, rx_n = 0, tx_lastn = 0, rx_lastn = 0, fc_n = 0, abort_n = 0;
    logic [1:0] rx_stat_last = 2'b00;
    logic [1:0] rx_stat_other = 2'b00;

    always @(negedge clk) begin
        #1;
        if (mac_tx_valid) begin
            tx_cap[tx_n[7:0]]  = mac_tx_data;
            tx_lcap[tx_n[7:0]] = mac_tx_last;
            tx_n++;
            if (mac_tx_last) tx_lastn++;
        end
        if (rx_valid) begin
            rx_cap[rx_n[7:0]] = rx_data;
            rx_n++;
            if (rx_last) begin
                rx_lastn++;
                rx_stat_last = rx_status;
            end else begin
                rx_stat_other = rx_stat_other | rx_status;
            end
        end
        if (link_tx_fc)   fc_n++;
        if (mac_tx_abort) abort_n++;
    end

    logic [7:0] frm [0:15];

    function automatic logic [31:0] ref_fcs(input int n);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ frm[i][k];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return ~c;
    endfunction

    task automatic load_data();
        frm[0] = 8'h11; frm[1] = 8'h22; frm[2] = 8'h33; frm[3] = 8'hC4; frm[4] = 8'h5A;
    endtask

    task automatic send_tx(input int n, input bit req, input int gap_at, input int gap_len);
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) begin
                for (int g = 0; g < gap_len; g++) begin
                    @(negedge clk);
                    tx_valid = 1'b0;
                end
            end
            @(negedge clk);
            tx_valid = 1'b1; tx_data = frm[i]; tx_last = (i == n - 1); tx_crc_req = req;
            while (!tx_ready) @(negedge clk);
        end
        @(negedge clk);
        tx_valid = 1'b0; tx_last = 1'b0; tx_crc_req = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_rx(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mac_rx_valid = 1'b1; mac_rx_data = frm[i]; mac_rx_last = (i == n - 1);
        end
        @(negedge clk);
        mac_rx_valid = 1'b0; mac_rx_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Check a transmitted 5-byte frame followed by its CRC
    task automatic check_tx_frame(input int base, input int lbase, input string req);
        logic [31:0] f;
        f = ref_fcs(5);
        check(tx_n - base == 9, req, tx_n - base, 9);
        for (int i = 0; i < 5; i++)
            check(tx_cap[8'(base + i)] == frm[i], "R3", tx_cap[8'(base + i)], frm[i]);
        for (int i = 0; i < 4; i++)
            check(tx_cap[8'(base + 5 + i)] == f[8*i +: 8], "R1",
                  tx_cap[8'(base + 5 + i)], f[8*i +: 8]);
        check(tx_lcap[8'(base + 8)] == 1'b1 && tx_lastn - lbase == 1, "R1",
              tx_lastn - lbase, 1);
    endtask

    // Flow-control vectors {mode[1:0], force, rx_en, pause, expected link_rx_fc}
    localparam logic [5:0] FC_VEC [0:7] = '{
        6'b01_1_0_0_1, 6'b01_0_0_1_0, 6'b01_0_1_1_1, 6'b01_0_1_0_0,
        6'b00_1_0_0_0, 6'b00_0_1_1_1, 6'b10_1_0_0_0, 6'b00_1_1_1_1
    };

    initial begin
        #(4 * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int b, lb, rb, rl, fb, ab;
        logic [31:0] f;
        rst_n = 1'b0;
        cfg_crc_append = 1'b1; cfg_crc_check = 1'b1; cfg_loopback = 1'b0;
        cfg_rx_fc_en = 1'b1; cfg_tx_fc_en = 1'b0; cfg_force_fc = 1'b0;
        cfg_sig_mode = 2'b00; rx_pause_req = 1'b0;
        tx_valid = 1'b0; tx_data = 8'h00; tx_last = 1'b0; tx_crc_req = 1'b0;
        mac_rx_valid = 1'b0; mac_rx_data = 8'h00; mac_rx_last = 1'b0;
        for (int i = 0; i < 16; i++) frm[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        // R12: reset state
        check(tx_ready && !mac_tx_valid && !rx_valid && !tx_underrun, "R12",
              {tx_ready, mac_tx_valid, rx_valid, tx_underrun}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(tx_ready && !mac_tx_valid && !tx_underrun, "R12",
              {tx_ready, mac_tx_valid, tx_underrun}, 3'b100);

        // R8 / R9: flow-control table
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            cfg_sig_mode = FC_VEC[v][5:4]; cfg_force_fc = FC_VEC[v][3];
            cfg_rx_fc_en = FC_VEC[v][2];  rx_pause_req = FC_VEC[v][1];
            #1;
            check(link_rx_fc == FC_VEC[v][0], "R8 R9 link_rx_fc", link_rx_fc, FC_VEC[v][0]);
        end
        @(negedge clk);
        cfg_sig_mode = 2'b00; cfg_force_fc = 1'b0; cfg_rx_fc_en = 1'b1; rx_pause_req = 1'b0;

        // R3: one-cycle latency on a single-byte frame without CRC
        cfg_crc_append = 1'b0;
        @(negedge clk);
        tx_valid = 1'b1; tx_data = 8'hA7; tx_last = 1'b1; tx_crc_req = 1'b0;
        @(negedge clk);
        tx_valid = 1'b0; tx_last = 1'b0;
        #1;
        check(mac_tx_valid && mac_tx_data == 8'hA7 && mac_tx_last, "R3 latency",
              {mac_tx_valid, mac_tx_last, mac_tx_data}, {2'b11, 8'hA7});
        repeat (4) @(negedge clk);

        // R1/R2: global append on, request off
        load_data();
        cfg_crc_append = 1'b1;
        b = tx_n; lb = tx_lastn;
        send_tx(5, 1'b0, -1, 0);
        check_tx_frame(b, lb, "R2 global append");
        // R2: global append on, request on
        b = tx_n; lb = tx_lastn;
        send_tx(5, 1'b1, -1, 0);
        check_tx_frame(b, lb, "R2 append with request");
        // R2: global off, per-frame request on
        cfg_crc_append = 1'b0;
        b = tx_n; lb = tx_lastn;
        send_tx(5, 1'b1, -1, 0);
        check_tx_frame(b, lb, "R2 per-frame request");
        // R2: global off, no request
        b = tx_n; lb = tx_lastn;
        send_tx(5, 1'b0, -1, 0);
        check(tx_n - b == 5, "R2 no CRC count", tx_n - b, 5);
        check(tx_lcap[8'(b + 4)] == 1'b1 && tx_lastn - lb == 1, "R2 last on data",
              tx_lastn - lb, 1);

        // R4: good frame on receive
        f = ref_fcs(5);
        for (int i = 0; i < 4; i++) frm[5 + i] = f[8*i +: 8];
        rl = rx_lastn;
        send_rx(9);
        check(rx_lastn - rl == 1 && rx_stat_last == 2'b00, "R4 good frame", rx_stat_last, 2'b00);
        // R4: corrupted frame
        frm[2] = frm[2] ^ 8'h10;
        send_rx(9);
        check(rx_stat_last == 2'b01, "R4 corrupted frame", rx_stat_last, 2'b01);
        check(rx_stat_other == 2'b00, "R4 status only on last", rx_stat_other, 2'b00);
        // R6: checking disabled
        cfg_crc_check = 1'b0;
        send_rx(9);
        check(rx_stat_last == 2'b00, "R6 check off", rx_stat_last, 2'b00);
        cfg_crc_check = 1'b1;
        // R5: short frame
        load_data();
        send_rx(3);
        check(rx_stat_last == 2'b11, "R5 short frame", rx_stat_last, 2'b11);

        // R7: loopback with junk on the MAC receive inputs
        cfg_loopback = 1'b1; cfg_crc_append = 1'b1;
        @(negedge clk);
        mac_rx_valid = 1'b1; mac_rx_data = 8'hEE; mac_rx_last = 1'b0;
        b = tx_n; rb = rx_n; rl = rx_lastn;
        send_tx(5, 1'b0, -1, 0);
        mac_rx_valid = 1'b0;
        f = ref_fcs(5);
        for (int i = 0; i < 4; i++) frm[5 + i] = f[8*i +: 8];
        check(tx_n == b, "R7 MAC quiet", tx_n - b, 0);
        check(rx_n - rb == 9, "R7 rx count", rx_n - rb, 9);
        for (int i = 0; i < 9; i++)
            check(rx_cap[8'(rb + i)] == frm[i], "R7 rx byte", rx_cap[8'(rb + i)], frm[i]);
        check(rx_lastn - rl == 1 && rx_stat_last == 2'b00, "R7 looped status",
              rx_stat_last, 2'b00);
        cfg_loopback = 1'b0;
        repeat (3) @(negedge clk);

        // R10: hole with transmit flow control in encoded mode
        load_data();
        cfg_sig_mode = 2'b01; cfg_tx_fc_en = 1'b1;
        b = tx_n; lb = tx_lastn; fb = fc_n; ab = abort_n;
        send_tx(5, 1'b0, 2, 2);
        check(fc_n - fb == 2, "R10 pause cycles", fc_n - fb, 2);
        check(abort_n == ab && !tx_underrun, "R10 no underrun", tx_underrun, 0);
        check_tx_frame(b, lb, "R10 frame resumes");

        // R11: same hole in GMII mode is an underrun
        cfg_sig_mode = 2'b00;
        b = tx_n; lb = tx_lastn; fb = fc_n; ab = abort_n;
        send_tx(5, 1'b0, 2, 2);
        check(tx_n - b == 2, "R11 bytes before abort", tx_n - b, 2);
        check(abort_n - ab == 1, "R11 abort pulse", abort_n - ab, 1);
        check(tx_lastn == lb && fc_n == fb, "R11 tail dropped", tx_lastn - lb, 0);
        check(tx_underrun == 1'b1, "R11 underrun set", tx_underrun, 1);
        b = tx_n;
        send_tx(5, 1'b0, -1, 0);
        check(tx_n - b == 9 && tx_underrun == 1'b1, "R11 sticky", tx_underrun, 1);

        // R12: reset clears the sticky flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!tx_underrun && tx_ready, "R12 reset clears", tx_underrun, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule